// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo stream into parallel sample pairs. The stream has a bit clock, a word clock that marks the left and right halves of each frame, and one data line. All three lines are oversampled in the system clock domain through a synchronizer chain. A rising bit clock is found by comparing the synchronized level with its previous value, so no logic runs on the bit clock itself.

A 3-bit format input selects how words sit inside each word-clock half. The word may be pushed against the end of the half (right aligned), start on the first bit (left aligned), or start one bit late with the word clock polarity flipped (I2S). The word length can be 16, 20 or 24 bits.

Each complete frame gives one strobe. At that strobe the left and right samples appear together, sign-extended to the output width, and they hold until the next strobe. The block is meant to sit behind a pin mux or a codec port, in front of a sample FIFO or a filter chain.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is asserted and directly after it is released, `smp_valid_o` is low and `left_o` and `right_o` are zero.
- R2: A data bit is taken at each rising edge of the bit clock. Words are most significant bit first, in two's complement.
- R3: Format codes 3'b000, 3'b001 and 3'b010 are right aligned, with 16, 20 and 24 bits. Only the last N bits before the word-clock transition are kept, and every earlier bit in that half is ignored.
- R4: Format code 3'b011 is left aligned with 24 bits. The most significant bit is the first bit taken after the word-clock transition, and bits after the 24th are ignored.
- R5: Format codes 3'b100 (16 bits) and 3'b101 (24 bits) are I2S. The first bit after the transition is ignored, the most significant bit is the second bit, and bits after the word are ignored.
- R6: In the right and left aligned formats, a high word clock carries the left sample. In the I2S formats, a low word clock carries the left sample.
- R7: Words shorter than the output width are sign-extended from their own top bit.
- R8: With format code 3'b110 or 3'b111, `smp_valid_o` stays low and the outputs keep their values.
- R9: Exactly one single-cycle strobe is given per complete left-then-right frame. Both outputs are updated in that cycle and hold between strobes.
- R10: A half that was already under way when reset was released is discarded, and so is a right word that has no left word before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock, sampled by `clk` |
| wclk_i | input | 1 | Word clock that selects the channel, sampled by `clk` |
| sdata_i | input | 1 | Serial data, sampled by `clk` |
| fmt_i | input | 3 | Framing code: 000/001/010 right aligned 16/20/24, 011 left aligned 24, 100/101 I2S 16/24, 110/111 reserved |
| smp_valid_o | output | 1 | One-cycle strobe when a new stereo pair is presented |
| left_o | output | SAMPLE_W | Left sample, sign-extended |
| right_o | output | SAMPLE_W | Right sample, sign-extended |

## Verification
A wrong bit-position counter or a wrong window test shows up as a sample shifted by one bit, or with foreign bits mixed in. This is visible on the first strobe after the bad capture, which comes one frame later. A wrong channel polarity swaps `left_o` and `right_o` on the first pair. A lost pending-left flag or a bad arming flag changes the number of strobes per burst, which shows at the end of that burst. Junk bits sit outside every word window, so a capture window that is too wide corrupts the compared values at once.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [2:0] {
      FMT_RJ16  = 3'b000,
      FMT_RJ20  = 3'b001,
      FMT_RJ24  = 3'b010,
      FMT_LJ24  = 3'b011,
      FMT_I2S16 = 3'b100,
      FMT_I2S24 = 3'b101,
      FMT_RSV6  = 3'b110,
      FMT_RSV7  = 3'b111
   } fmt_code_e;

   // ok: legal code; rj: word pinned to end of half; i2s: inverted polarity
   // lead: bits skipped after the transition; len: word length
   typedef struct packed {
      logic       ok;
      logic       rj;
      logic       i2s;
      logic [1:0] lead;
      logic [5:0] len;
   } fmt_cfg_t;

   function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
      fmt_cfg_t c;
      c = '0;
      case (fmt_code_e'(code))
         FMT_RJ16:  begin c.ok = 1'b1; c.rj = 1'b1; c.len = 6'd16; end
         FMT_RJ20:  begin c.ok = 1'b1; c.rj = 1'b1; c.len = 6'd20; end
         FMT_RJ24:  begin c.ok = 1'b1; c.rj = 1'b1; c.len = 6'd24; end
         FMT_LJ24:  begin c.ok = 1'b1; c.len = 6'd24; end
         FMT_I2S16: begin c.ok = 1'b1; c.i2s = 1'b1; c.lead = 2'd1; c.len = 6'd16; end
         FMT_I2S24: begin c.ok = 1'b1; c.i2s = 1'b1; c.lead = 2'd1; c.len = 6'd24; end
         default:   c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [WIDTH-1:0] r;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '0;
               else        r <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '0;
               else        r <= g_stage[s-1].r;
            end
         end
      end
   endgenerate

   assign q_o = g_stage[STAGES-1].r;

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
   import aud_rx_pkg::*;
#(
   parameter int SAMPLE_W   = 24,
   parameter int SLOT_CNT_W = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_s,
   input  logic                wclk_s,
   input  logic                data_s,
   input  fmt_cfg_t            cfg,
   output logic                word_stb_o,
   output logic                word_left_o,
   output logic [SAMPLE_W-1:0] word_o
);

   localparam logic [SLOT_CNT_W-1:0] POS_MAX = {SLOT_CNT_W{1'b1}};

   logic                  bclk_q;
   logic                  wclk_last;
   logic                  have_bit;
   logic                  armed;
   logic [SLOT_CNT_W-1:0] pos;
   logic [SAMPLE_W-1:0]   rj_sh;
   logic [SAMPLE_W-1:0]   lj_sh;
   logic [SAMPLE_W-1:0]   len_mask;
   logic                  bit_stb;
   logic                  edge_hit;
   logic                  in_win;
   logic [SLOT_CNT_W-1:0] win_lo;
   logic [SLOT_CNT_W-1:0] win_hi;

   assign bit_stb  = bclk_s & ~bclk_q;
   assign edge_hit = have_bit & (wclk_s != wclk_last);
   assign win_lo   = SLOT_CNT_W'(cfg.lead);
   assign win_hi   = SLOT_CNT_W'(cfg.lead) + SLOT_CNT_W'(cfg.len);
   assign in_win   = (pos >= win_lo) && (pos < win_hi);

   always_comb begin
      for (int i = 0; i < SAMPLE_W; i++) begin
         len_mask[i] = (i < int'(cfg.len));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q      <= 1'b0;
         wclk_last   <= 1'b0;
         have_bit    <= 1'b0;
         armed       <= 1'b0;
         pos         <= '0;
         rj_sh       <= '0;
         lj_sh       <= '0;
         word_stb_o  <= 1'b0;
         word_left_o <= 1'b0;
         word_o      <= '0;
      end else begin
         bclk_q     <= bclk_s;
         word_stb_o <= 1'b0;
         if (bit_stb) begin
            have_bit  <= 1'b1;
            wclk_last <= wclk_s;
            rj_sh     <= {rj_sh[SAMPLE_W-2:0], data_s};
            if (edge_hit) begin
               armed <= 1'b1;
               pos   <= SLOT_CNT_W'(1);
               lj_sh <= (cfg.lead == 2'd0) ? SAMPLE_W'(data_s) : '0;
               if (armed && cfg.ok) begin
                  word_stb_o  <= 1'b1;
                  word_left_o <= wclk_last ^ cfg.i2s;
                  word_o      <= (cfg.rj ? rj_sh : lj_sh) & len_mask;
               end
            end else begin
               if (pos != POS_MAX) pos <= pos + 1'b1;
               if (in_win) lj_sh <= {lj_sh[SAMPLE_W-2:0], data_s};
            end
         end
      end
   end

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fmt_ok,
   input  logic [5:0]          word_len,
   input  logic                word_stb_i,
   input  logic                word_left_i,
   input  logic [SAMPLE_W-1:0] word_i,
   output logic                smp_valid_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o
);

   logic [SAMPLE_W-1:0] left_hold;
   logic                have_left;
   logic [SAMPLE_W-1:0] word_ext;

   function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] raw,
                                                input logic [5:0] len);
      logic                sgn;
      logic [SAMPLE_W-1:0] res;
      sgn = (len == 6'd0) ? 1'b0 : raw[int'(len) - 1];
      for (int i = 0; i < SAMPLE_W; i++) begin
         res[i] = (i < int'(len)) ? raw[i] : sgn;
      end
      return res;
   endfunction

   assign word_ext = sext(word_i, word_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold   <= '0;
         have_left   <= 1'b0;
         smp_valid_o <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
      end else begin
         smp_valid_o <= 1'b0;
         if (!fmt_ok) begin
            have_left <= 1'b0;
         end else if (word_stb_i) begin
            if (word_left_i) begin
               left_hold <= word_ext;
               have_left <= 1'b1;
            end else if (have_left) begin
               left_o      <= left_hold;
               right_o     <= word_ext;
               smp_valid_o <= 1'b1;
               have_left   <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
   import aud_rx_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SYNC_STAGES = 2,
   parameter int SLOT_CNT_W  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                wclk_i,
   input  logic                sdata_i,
   input  logic [2:0]          fmt_i,
   output logic                smp_valid_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o
);

   localparam int LINES = 3;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SAMPLE_W < 24) begin : g_bad_width
         $error("SAMPLE_W must hold a 24-bit word");
      end
      if (SLOT_CNT_W < 6) begin : g_bad_cnt
         $error("SLOT_CNT_W too small for a 24-bit window");
      end
   endgenerate

   fmt_cfg_t            cfg;
   logic [LINES-1:0]    lines_s;
   logic                word_stb;
   logic                word_left;
   logic [SAMPLE_W-1:0] word;

   assign cfg = decode_fmt(fmt_i);

   aud_rx_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, wclk_i, sdata_i}),
      .q_o   (lines_s)
   );

   aud_rx_deser #(
      .SAMPLE_W   (SAMPLE_W),
      .SLOT_CNT_W (SLOT_CNT_W)
   ) u_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk_s      (lines_s[2]),
      .wclk_s      (lines_s[1]),
      .data_s      (lines_s[0]),
      .cfg         (cfg),
      .word_stb_o  (word_stb),
      .word_left_o (word_left),
      .word_o      (word)
   );

   aud_rx_pair #(
      .SAMPLE_W (SAMPLE_W)
   ) u_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt_ok      (cfg.ok),
      .word_len    (cfg.len),
      .word_stb_i  (word_stb),
      .word_left_i (word_left),
      .word_i      (word),
      .smp_valid_o (smp_valid_o),
      .left_o      (left_o),
      .right_o     (right_o)
   );

endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic [2:0]          fmt_i,
   input logic                smp_valid_o,
   input logic [SAMPLE_W-1:0] left_o,
   input logic [SAMPLE_W-1:0] right_o
);

   AST_RST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!smp_valid_o && left_o == '0 && right_o == '0)); // R1

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_o |=> !smp_valid_o); // R9

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid_o |-> ($stable(left_o) && $stable(right_o))); // R9

   AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fmt_i[2:1]) == 2'b11) |-> !smp_valid_o); // R8

   AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_o && ($past(fmt_i) == 3'b000 || $past(fmt_i) == 3'b100)) |->
      (right_o[SAMPLE_W-1:15] == '0 || right_o[SAMPLE_W-1:15] == '1)); // R7

   AST_SEXT_20: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_o && $past(fmt_i) == 3'b001) |->
      (right_o[SAMPLE_W-1:19] == '0 || right_o[SAMPLE_W-1:19] == '1)); // R7

endmodule

bind aud_ser_rx aud_ser_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fmt_i       (fmt_i),
   .smp_valid_o (smp_valid_o),
   .left_o      (left_o),
   .right_o     (right_o)
);

// File: tb/aud_ser_rx_tb.sv
module aud_ser_rx_tb;

   localparam int HB = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        wclk = 1'b0;
   logic        sdata = 1'b0;
   logic [2:0]  fmt = 3'b000;
   logic        smp_valid;
   logic [23:0] left_s;
   logic [23:0] right_s;

   int          n_chk = 0;
   int          n_err = 0;
   int          n_stb = 0;
   string       cur_tag = "R2";
   logic [23:0] exp_l[$];
   logic [23:0] exp_r[$];

   always #4 clk = ~clk;

   aud_ser_rx u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk_i      (bclk),
      .wclk_i      (wclk),
      .sdata_i     (sdata),
      .fmt_i       (fmt),
      .smp_valid_o (smp_valid),
      .left_o      (left_s),
      .right_o     (right_s)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] sext(input logic [23:0] raw, input int n);
      logic [23:0] r;
      for (int i = 0; i < 24; i++) r[i] = (i < n) ? raw[i] : raw[n-1];
      return r;
   endfunction

   always @(negedge clk) begin
      if (rst_n && smp_valid) begin
         n_stb++;
         if (exp_l.size() == 0) begin
            chk({cur_tag, " R8 R9 unexpected strobe"}, 32'd1, 32'd0);
         end else begin
            chk({cur_tag, " R6 left"}, {8'h0, left_s}, {8'h0, exp_l.pop_front()});
            chk({cur_tag, " R6 right"}, {8'h0, right_s}, {8'h0, exp_r.pop_front()});
         end
      end
   end

   task automatic send_bit(input logic w, input logic d);
      wclk  = w;
      sdata = d;
      bclk  = 1'b0;
      repeat (HB) @(negedge clk);
      bclk = 1'b1;
      repeat (HB) @(negedge clk);
   endtask

   // mode 0 right aligned, 1 left aligned, 2 I2S
   task automatic send_half(input logic w, input int slot, input int mode,
                            input int n, input logic [23:0] word);
      for (int i = 0; i < slot; i++) begin
         logic b;
         b = 1'($urandom);
         if (mode == 0 && i >= slot - n) b = word[n-1-(i-(slot-n))];
         if (mode == 1 && i < n)         b = word[n-1-i];
         if (mode == 2 && i >= 1 && i <= n) b = word[n-i];
         send_bit(w, b);
      end
   endtask

   task automatic run_burst(input logic [2:0] code, input int mode, input int n,
                            input int slot, input int frames, input bit lead_in,
                            input string tag);
      logic ll;
      int   base;
      int   expect_cnt;
      cur_tag = tag;
      rst_n = 1'b0;
      fmt   = code;
      bclk  = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      base = n_stb;
      ll = (mode == 2) ? 1'b0 : 1'b1;
      if (lead_in) send_half(~ll, slot, mode, n, 24'h0);
      expect_cnt = 0;
      for (int f = 0; f < frames; f++) begin
         logic [23:0] lw;
         logic [23:0] rw;
         lw = 24'($urandom);
         rw = 24'($urandom);
         if (f == 0) begin
            lw = 24'((1 << (n-1)) - 1);
            rw = 24'(1 << (n-1));
         end else if (f == 1) begin
            lw = 24'hFFFFFF;
            rw = 24'h0;
         end
         if (code[2:1] != 2'b11 && (lead_in || f > 0)) begin
            exp_l.push_back(sext(lw, n));
            exp_r.push_back(sext(rw, n));
            expect_cnt++;
         end
         send_half(ll, slot, mode, n, lw);
         send_half(~ll, slot, mode, n, rw);
      end
      send_half(ll, slot, mode, n, 24'h0);
      chk({tag, " R9 R10 strobe count"}, 32'(n_stb - base), 32'(expect_cnt));
      chk({tag, " R9 pending pairs"}, 32'(exp_l.size()), 32'd0);
      exp_l.delete();
      exp_r.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 strobe in reset", {31'h0, smp_valid}, 32'd0);
      chk("R1 left in reset", {8'h0, left_s}, 32'd0);
      chk("R1 right in reset", {8'h0, right_s}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 strobe after release", {31'h0, smp_valid}, 32'd0);
      chk("R1 left after release", {8'h0, left_s}, 32'd0);
      run_burst(3'b000, 0, 16, 32, 6, 1'b1, "R3 R2 R7");
      run_burst(3'b001, 0, 20, 32, 6, 1'b1, "R3 R7");
      run_burst(3'b010, 0, 24, 24, 6, 1'b1, "R3 R2");
      run_burst(3'b000, 0, 16, 16, 5, 1'b1, "R3");
      run_burst(3'b011, 1, 24, 32, 6, 1'b1, "R4");
      run_burst(3'b011, 1, 24, 24, 4, 1'b1, "R4");
      run_burst(3'b100, 2, 16, 32, 6, 1'b1, "R5 R7");
      run_burst(3'b101, 2, 24, 32, 6, 1'b1, "R5");
      run_burst(3'b110, 0, 24, 32, 4, 1'b1, "R8");
      chk("R8 left untouched", {8'h0, left_s}, 32'd0);
      run_burst(3'b111, 2, 24, 32, 4, 1'b1, "R8");
      chk("R8 right untouched", {8'h0, right_s}, 32'd0);
      run_burst(3'b010, 0, 24, 32, 5, 1'b0, "R10");
      run_burst(3'b100, 2, 16, 32, 5, 1'b0, "R10");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule